// File: doc/BRIEF.md
# SPI Register Access Slave

This block is a serial slave that lets an external host read and write a bank of 32 eight-bit registers over a four-wire SPI link. Every transfer is a fixed 16-bit frame. The host sends a header byte and then a data byte. While it does so, the slave shifts back a status byte followed by the contents of the addressed register.

The header byte is sent MSB first. It holds a read/write flag, a 5-bit register address, an even-parity bit covering the flag and the address, and one spare bit. All three link inputs are oversampled by a fast system clock through two-flop synchronizers, and every edge is found in that clock domain. The register bank sits outside the block and is reached through one read port (address out, data in) and one write port (strobe, address, data).

The slave counts the sampling edges inside each frame and checks parity on write frames. It commits a write only when SS rises at the end of a frame that passed both checks. A frame that fails either check leaves the bank untouched and produces a one-cycle error pulse.

Top module: `spi_regport_top`

## Requirements
- R1: A frame begins when SS falls and ends when SS rises. It is valid only if exactly 16 falling SCK edges occur while SS is low. SCK and MOSI activity while SS is high is ignored.
- R2: `miso_oe` is 0 while SS is high. It goes to 1 within a few system clocks of SS falling and returns to 0 after SS rises.
- R3: MISO changes only in response to a rising SCK edge. The first frame bit appears after the first rising edge, and it holds steady through the following falling edge. MOSI is sampled on falling SCK edges.
- R4: The host header is sent MSB first in this order: bit 15 is the read/write flag (1 = read), bits 14..10 are the address (MSB first), bit 9 is the parity bit and bit 8 is a spare bit. Bits 7..0 are write data, MSB first. The spare bit has no effect.
- R5: Frame bits 1 to 8 returned on MISO carry `status_in`, MSB first, as it stood when SS fell.
- R6: Frame bits 9 to 16 returned on MISO carry the addressed register, MSB first. The value is captured on the 7th falling SCK edge, so on a write frame the slave returns the value from before the write.
- R7: A read frame never writes, whatever its data byte holds, and its parity bit is not checked.
- R8: A 16-edge write frame whose parity bit equals the XOR of the flag and the five address bits pulses `wr_en` for exactly one cycle just after SS rises, with `wr_addr` set to the address and `wr_data` set to the data byte.
- R9: A frame with fewer or more than 16 falling edges produces no write and pulses `frame_err` for one cycle.
- R10: A write frame with a wrong parity bit produces no write and pulses `frame_err` for one cycle. `wr_en` and `frame_err` are never high together.
- R11: After reset, `miso_oe`, `wr_en` and `frame_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCK |
| rst | input | 1 | Synchronous active-high reset |
| ss_n | input | 1 | Slave select, active low |
| sck | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from the host |
| status_in | input | 8 | Status byte returned in the first half of each frame |
| rd_data | input | 8 | Register contents at `rd_addr` |
| rd_addr | output | 5 | Register address for the read port |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | 5 | Write address |
| wr_data | output | 8 | Write data |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Drive enable for the MISO pad |
| frame_err | output | 1 | One-cycle pulse for a rejected frame |

## Verification
The assertions assume that each SCK level lasts several system clocks. They also assume that MOSI changes only together with a rising SCK edge, and that SCK is low whenever SS changes. Under these conditions the synchronized edge pulses never overlap and each pulse stands for exactly one pin edge. The bench holds every SCK phase for 8 system clocks, which is well above the 8x ratio. It changes MOSI and SCK on the falling system-clock edge, and it leaves several idle clocks between an SS edge and the nearest SCK edge.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = 2 * DATA_W;

    // Host header byte, transmitted MSB first
    typedef struct packed {
        logic              rd;     // 1 = read, 0 = write
        logic [ADDR_W-1:0] addr;
        logic              par;
        logic              spare;
    } hdr_t;

    function automatic logic hdr_parity(input logic rd, input logic [ADDR_W-1:0] addr);
        return ^{rd, addr};
    endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int             N       = 3,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES:0] pipe;

        always_ff @(posedge clk) begin
            if (rst) pipe <= {(STAGES+1){RST_VAL[g]}};
            else     pipe <= {pipe[STAGES-1:0], din[g]};
        end

        assign lvl[g]  = pipe[STAGES-1];
        assign rise[g] = pipe[STAGES-1] & ~pipe[STAGES];
        assign fall[g] = ~pipe[STAGES-1] & pipe[STAGES];
    end

endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
    import spi_regport_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ss_rise,
    input  logic          ss_fall,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          mosi_s,
    input  logic [DW-1:0] status_in,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          miso,
    output logic          miso_oe,
    output logic          frame_err
);

    localparam int NBITS = 2 * DW;
    localparam int CNT_W = $clog2(NBITS + 2);
    localparam int IDX_W = $clog2(NBITS);
    localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(NBITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(NBITS);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(AW);      // 6th edge in progress
    localparam logic [CNT_W-1:0] PAR_EDGE  = CNT_W'(AW + 1);  // 7th edge in progress

    logic             active;
    logic [CNT_W-1:0] fall_cnt, rise_cnt;
    logic [NBITS-1:0] rx;
    logic [DW-1:0]    status_q, rd_q;
    logic [AW-1:0]    addr_q;
    logic             miso_q;

    hdr_t             hdr;
    logic             par_ok, frame_ok;
    logic [NBITS-1:0] tx_word;
    logic [IDX_W-1:0] tx_idx;
    logic             tx_bit;

    assign hdr      = hdr_t'(rx[NBITS-1 -: DW]);
    assign par_ok   = (hdr.par == hdr_parity(hdr.rd, hdr.addr));
    assign frame_ok = (fall_cnt == CNT_FULL) && (hdr.rd || par_ok);

    assign tx_word = {status_q, rd_q};
    assign tx_idx  = IDX_W'(NBITS - 1) - rise_cnt[IDX_W-1:0];
    assign tx_bit  = (rise_cnt < CNT_FULL) ? tx_word[tx_idx] : 1'b0;

    always_ff @(posedge clk) begin
        wr_en     <= 1'b0;
        frame_err <= 1'b0;
        if (rst) begin
            active   <= 1'b0;
            fall_cnt <= '0;
            rise_cnt <= '0;
            rx       <= '0;
            status_q <= '0;
            rd_q     <= '0;
            addr_q   <= '0;
            miso_q   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (ss_fall) begin
            active   <= 1'b1;
            fall_cnt <= '0;
            rise_cnt <= '0;
            status_q <= status_in;
            rd_q     <= '0;
            miso_q   <= 1'b0;
        end else if (active) begin
            if (ss_rise) begin
                active    <= 1'b0;
                wr_en     <= frame_ok && !hdr.rd;
                frame_err <= !frame_ok;
                wr_addr   <= addr_q;
                wr_data   <= rx[DW-1:0];
            end else begin
                if (sck_fall) begin
                    rx <= {rx[NBITS-2:0], mosi_s};
                    if (fall_cnt != CNT_SAT)
                        fall_cnt <= fall_cnt + 1'b1;
                    if (fall_cnt == ADDR_LAST)
                        addr_q <= {rx[AW-2:0], mosi_s};
                    if (fall_cnt == PAR_EDGE)
                        rd_q <= rd_data;
                end
                if (sck_rise) begin
                    if (rise_cnt != CNT_SAT)
                        rise_cnt <= rise_cnt + 1'b1;
                    miso_q <= tx_bit;
                end
            end
        end
    end

    assign rd_addr = addr_q;
    assign miso    = miso_q;
    assign miso_oe = active;

    AST_OE_FROM_SS: assert property (@(posedge clk) disable iff (rst)
        $rose(miso_oe) |-> $past(ss_fall));                                   // R2
    AST_MISO_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (!sck_rise && !ss_fall) |=> $stable(miso));                           // R3
    AST_WR_AT_SS_RISE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(ss_rise));                                            // R8
    AST_WR_FULL_FRAME: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(fall_cnt) == CNT_FULL));                             // R9
    AST_WR_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && frame_err));                                               // R10
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);                                            // R10

endmodule

// File: rtl/spi_regport_top.sv
module spi_regport_top
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ss_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              miso,
    output logic              miso_oe,
    output logic              frame_err
);

    // bit 0 = ss_n (resets high), bit 1 = sck, bit 2 = mosi
    logic [2:0] s_lvl, s_rise, s_fall;

    spi_regport_sync #(.N(3), .STAGES(2), .RST_VAL(3'b001)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({mosi, sck, ss_n}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    spi_regport_frame #(.AW(ADDR_W), .DW(DATA_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .ss_rise   (s_rise[0]),
        .ss_fall   (s_fall[0]),
        .sck_rise  (s_rise[1]),
        .sck_fall  (s_fall[1]),
        .mosi_s    (s_lvl[2]),
        .status_in (status_in),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .miso      (miso),
        .miso_oe   (miso_oe),
        .frame_err (frame_err)
    );

endmodule

// File: tb/spi_regport_top_bench.sv
module spi_regport_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ss_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic [7:0] status_in = 8'h00;
    logic [7:0] rd_data;
    logic [4:0] rd_addr, wr_addr;
    logic [7:0] wr_data;
    logic       wr_en, miso, miso_oe, frame_err;

    int n_vec = 0;
    int n_bad = 0;
    int we_cnt = 0;
    int err_cnt = 0;
    logic [7:0] bank  [32];
    logic [7:0] model [32];

    always #5 clk = ~clk;

    spi_regport_top u_spi_regport_top (
        .clk(clk), .rst(rst), .ss_n(ss_n), .sck(sck), .mosi(mosi),
        .status_in(status_in), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .miso(miso), .miso_oe(miso_oe), .frame_err(frame_err)
    );

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 7 + 3);
    endfunction

    // external register bank
    assign rd_data = bank[rd_addr];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 32; i++) bank[i] <= init_val(i);
        end else begin
            if (wr_en) begin
                bank[wr_addr] <= wr_data;
                we_cnt <= we_cnt + 1;
            end
            if (frame_err) err_cnt <= err_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] frame(input bit rd, input logic [4:0] a, input bit par_bad,
                                          input bit spare, input logic [7:0] d);
        logic p;
        p = (^{rd, a}) ^ par_bad;
        return {rd, a, p, spare, d};
    endfunction

    // Runs one transfer with nbits SCK pulses; checks R2 and R3 on the way.
    task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
        bit stab_ok = 1'b1;
        logic b, b1;
        rx = '0;
        @(negedge clk) ss_n = 1'b0;
        repeat (8) @(negedge clk);
        chk(miso_oe == 1'b1, "R2 oe on after SS fall", 16'(miso_oe), 16'h1);
        for (int i = 0; i < nbits; i++) begin
            sck  = 1'b1;
            mosi = (i < 16) ? tx[15 - i] : 1'b0;
            repeat (6) @(negedge clk);
            b1 = miso;
            repeat (2) @(negedge clk);
            b = miso;
            if (b != b1) stab_ok = 1'b0;
            if (i < 16) rx[15 - i] = b;
            sck = 1'b0;
            repeat (7) @(negedge clk);
            if (miso != b) stab_ok = 1'b0;
            repeat (1) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        ss_n = 1'b1;
        mosi = 1'b0;
        repeat (12) @(negedge clk);
        chk(stab_ok, "R3 MISO steady between rising edges", 16'(stab_ok), 16'h1);
        chk(miso_oe == 1'b0, "R2 oe off after SS rise", 16'(miso_oe), 16'h0);
    endtask

    task automatic t_reset();
        chk(miso_oe == 1'b0, "R11 reset miso_oe", 16'(miso_oe), 16'h0);
        chk(wr_en == 1'b0, "R11 reset wr_en", 16'(wr_en), 16'h0);
        chk(frame_err == 1'b0, "R11 reset frame_err", 16'(frame_err), 16'h0);
    endtask

    task automatic t_read(input logic [4:0] a, input logic [7:0] st, input bit par_bad, input logic [7:0] junk);
        logic [15:0] rx;
        int we0 = we_cnt, er0 = err_cnt;
        status_in = st;
        xfer(frame(1'b1, a, par_bad, 1'b0, junk), 16, rx);
        chk(rx[15:8] == st, "R5 status byte", 16'(rx[15:8]), 16'(st));
        chk(rx[7:0] == model[a], "R6 read data", 16'(rx[7:0]), 16'(model[a]));
        chk(we_cnt == we0, "R7 read does not write", 16'(we_cnt - we0), 16'h0);
        chk(err_cnt == er0, "R7 read parity unchecked", 16'(err_cnt - er0), 16'h0);
    endtask

    task automatic t_write(input logic [4:0] a, input logic [7:0] d, input bit spare);
        logic [15:0] rx;
        int we0 = we_cnt, er0 = err_cnt;
        xfer(frame(1'b0, a, 1'b0, spare, d), 16, rx);
        chk(rx[7:0] == model[a], "R6 write returns old value", 16'(rx[7:0]), 16'(model[a]));
        chk(we_cnt == we0 + 1, "R8 one write strobe", 16'(we_cnt - we0), 16'h1);
        chk(err_cnt == er0, "R8 no error on good write", 16'(err_cnt - er0), 16'h0);
        model[a] = d;
        chk(bank[a] == d, "R8 R4 value written", 16'(bank[a]), 16'(d));
    endtask

    task automatic t_bad(input logic [4:0] a, input logic [7:0] d, input bit par_bad, input int nbits, input string req);
        logic [15:0] rx;
        int we0 = we_cnt, er0 = err_cnt;
        xfer(frame(1'b0, a, par_bad, 1'b0, d), nbits, rx);
        chk(we_cnt == we0, {req, " no write"}, 16'(we_cnt - we0), 16'h0);
        chk(err_cnt == er0 + 1, {req, " one error pulse"}, 16'(err_cnt - er0), 16'h1);
        chk(bank[a] == model[a], {req, " register unchanged"}, 16'(bank[a]), 16'(model[a]));
    endtask

    task automatic t_idle_sck();
        int we0 = we_cnt, er0 = err_cnt;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) sck = 1'b1; mosi = 1'b1;
            repeat (8) @(negedge clk);
            sck = 1'b0;
            repeat (8) @(negedge clk);
        end
        mosi = 1'b0;
        chk(miso_oe == 1'b0 && we_cnt == we0 && err_cnt == er0, "R1 idle SCK ignored",
            16'(we_cnt - we0 + err_cnt - er0), 16'h0);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) model[i] = init_val(i);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_read(5'd3, 8'hA5, 1'b1, 8'hFF);
        t_read(5'd31, 8'h3C, 1'b0, 8'h00);
        t_write(5'd10, 8'h5C, 1'b1);           // R4 spare bit set
        t_read(5'd10, 8'h81, 1'b0, 8'h11);
        t_write(5'd21, 8'hC3, 1'b0);
        t_read(5'd21, 8'h00, 1'b1, 8'hAA);
        t_bad(5'd10, 8'h99, 1'b1, 16, "R10");
        t_bad(5'd21, 8'h12, 1'b0, 15, "R9 short");
        t_bad(5'd21, 8'h34, 1'b0, 17, "R9 long");
        t_idle_sck();
        t_read(5'd10, 8'h7E, 1'b0, 8'h00);
        t_read(5'd21, 8'h7E, 1'b0, 8'h00);
        t_write(5'd0, 8'hFF, 1'b0);
        t_read(5'd0, 8'h55, 1'b0, 8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule